// File: doc/BRIEF.md
# Serial Audio Interrupt Status Register

This block collects the interrupt-worthy events of a two-sequencer serial audio interface into one sticky status word. Each sequencer pulses four event inputs for a single cycle: a received word is ready, a received word was lost, the transmitter can take a new word, and the transmitter ran dry. Each pulse sets its own flag, and the flag stays set until software clears it.

An enable mask selects which flags can raise the single interrupt request line. Software reaches the flags and the mask over a small register bus with a combinational read path and single-cycle writes. The flag word is write-one-to-clear. The mask has separate set and clear addresses. The bus also carries one strobe for each sequencer's transmit data register. A strobe clears that sequencer's transmit-ready flag, so that a refill of the transmit data register also acknowledges the flag.

The bus and event pins are plain control and status signals. The block has no valid/ready stream and applies no back-pressure: every write and every event pulse takes effect at the clock edge where it is present.

Top module: `sai_irq_status`

## Requirements
- R1: A synchronous active-low reset clears every flag, every enable bit and the interrupt request.
- R2: Flag word bit positions (seq 1 in the higher bit of each pair): receive-ready on bits 1:0, receive-overrun on bits 5:4, transmit-ready on bits 9:8, transmit-underrun on bits 13:12. The flag word reads at address 0.
- R3: Bits 3:2, 7:6, 11:10 and 15:14 read as zero at every address. Writing ones to them at any address changes nothing.
- R4: An event pulse sets its flag at the next clock edge, and the flag stays set for as long as no clear is applied.
- R5: A write to address 0 clears each flag whose data bit is one and leaves flags with a zero data bit unchanged.
- R6: A data-register strobe for sequencer s clears only the transmit-ready flag of sequencer s (bit 8+s).
- R7: When an event and a clear (write-one or strobe) for the same flag occur in the same cycle, the flag ends up set.
- R8: Writing ones to address 2 sets those enable bits, and writing ones to address 1 clears them. Reading address 1 or address 2 returns the enable mask.
- R9: The interrupt request is a register holding the OR of flags ANDed with enables, so it follows a change of a flag or an enable one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 flags, 1 enable clear, 2 enable set |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data of the selected register |
| data_wr | input | 2 | Per-sequencer transmit data register write strobe |
| ev_rx_ready | input | 2 | Receive-ready event pulse per sequencer |
| ev_rx_overrun | input | 2 | Receive-overrun event pulse per sequencer |
| ev_tx_ready | input | 2 | Transmit-ready event pulse per sequencer |
| ev_tx_underrun | input | 2 | Transmit-underrun event pulse per sequencer |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that the bus and event inputs are stable around the rising edge, and that reset is held low for at least one edge before it is released. The bench meets both by changing every input on the falling edge. It never presents an enable set and an enable clear in the same cycle, since the one-address bus cannot express that. On the other hand, it deliberately places events and clears in the same cycle to exercise the priority rule.

// File: rtl/sai_irq_pkg.sv
package sai_irq_pkg;
  localparam int WORD_W  = 16;
  localparam int GROUP_W = 4;
  localparam int NGROUP  = WORD_W / GROUP_W;

  // group index inside the status word (software-visible order)
  localparam int GRP_RX_READY   = 0;
  localparam int GRP_RX_OVERRUN = 1;
  localparam int GRP_TX_READY   = 2;
  localparam int GRP_TX_UNDERRUN = 3;

  typedef enum logic [1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_EN_CLR = 2'd1,
    SEL_EN_SET = 2'd2
  } reg_sel_e;

  // implemented-bit mask: the low nseq bits of every group
  function automatic logic [WORD_W-1:0] impl_mask(input int nseq);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int g = 0; g < NGROUP; g++)
      for (int s = 0; s < nseq; s++)
        m[g*GROUP_W + s] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sai_flag_bank.sv
module sai_flag_bank #(
  parameter int                W    = 16,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic q;
      // event has priority over clear so no pulse is lost
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_i[i]) | set_i[i];
      end
      assign flag_o[i] = q;

      a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> flag_o[i]);
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[i] && !clr_i[i]) |=> $stable(flag_o[i]));
      a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    end else begin : g_resv
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sai_irq_mask.sv
module sai_irq_mask #(
  parameter int           W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] en_clr_i,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] en_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= ((en_q & ~en_clr_i) | en_set_i) & MASK;
      irq_q <= |(flag_i & en_q);
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_i & en_o)) |=> irq_o);
  a_r9_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_i & en_o)) |=> !irq_o);
  a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    |(en_set_i & MASK) |=> ((en_o & $past(en_set_i) & MASK) == ($past(en_set_i) & MASK)));
  a_r8_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_i && !(|en_set_i)) |=> ((en_o & $past(en_clr_i)) == '0));
endmodule

// File: rtl/sai_irq_status.sv
module sai_irq_status
  import sai_irq_pkg::*;
#(
  parameter int NSEQ = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NSEQ-1:0]     data_wr,
  input  logic [NSEQ-1:0]     ev_rx_ready,
  input  logic [NSEQ-1:0]     ev_rx_overrun,
  input  logic [NSEQ-1:0]     ev_tx_ready,
  input  logic [NSEQ-1:0]     ev_tx_underrun,
  output logic                irq
);
  localparam logic [WORD_W-1:0] IMPL = impl_mask(NSEQ);

  logic [WORD_W-1:0] set_vec, clr_vec, flags, enables;
  logic [WORD_W-1:0] en_set, en_clr;
  logic              wr_flags, wr_en_set, wr_en_clr;

  assign wr_flags  = bus_wr && (bus_addr == SEL_FLAGS);
  assign wr_en_set = bus_wr && (bus_addr == SEL_EN_SET);
  assign wr_en_clr = bus_wr && (bus_addr == SEL_EN_CLR);

  always_comb begin
    set_vec = '0;
    clr_vec = wr_flags ? (bus_wdata & IMPL) : '0;
    for (int s = 0; s < NSEQ; s++) begin
      set_vec[GRP_RX_READY*GROUP_W + s]    = ev_rx_ready[s];
      set_vec[GRP_RX_OVERRUN*GROUP_W + s]  = ev_rx_overrun[s];
      set_vec[GRP_TX_READY*GROUP_W + s]    = ev_tx_ready[s];
      set_vec[GRP_TX_UNDERRUN*GROUP_W + s] = ev_tx_underrun[s];
      // refilling the transmit data register acknowledges transmit-ready
      clr_vec[GRP_TX_READY*GROUP_W + s] = clr_vec[GRP_TX_READY*GROUP_W + s] | data_wr[s];
    end
  end

  assign en_set = wr_en_set ? bus_wdata : '0;
  assign en_clr = wr_en_clr ? bus_wdata : '0;

  sai_flag_bank #(.W(WORD_W), .MASK(IMPL)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  sai_irq_mask #(.W(WORD_W), .MASK(IMPL)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_set_i (en_set),
    .en_clr_i (en_clr),
    .flag_i   (flags),
    .en_o     (enables),
    .irq_o    (irq)
  );

  always_comb begin
    unique case (bus_addr)
      SEL_FLAGS:            bus_rdata = flags;
      SEL_EN_CLR, SEL_EN_SET: bus_rdata = enables;
      default:              bus_rdata = '0;
    endcase
  end

  a_r3_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~IMPL) == '0);
  a_r6_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr[0] && !ev_tx_ready[0]) |=> !flags[GRP_TX_READY*GROUP_W]);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && enables == '0 && !irq));
endmodule

// File: tb/sai_irq_status_tb.sv
module sai_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  data_wr = '0;
  logic [1:0]  ev_rr = '0, ev_ro = '0, ev_tr = '0, ev_tu = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sai_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_wr(data_wr),
    .ev_rx_ready(ev_rr), .ev_rx_overrun(ev_ro), .ev_tx_ready(ev_tr),
    .ev_tx_underrun(ev_tu), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [1:0] rr, ro, tr, tu);
    @(negedge clk);
    ev_rr = rr; ev_ro = ro; ev_tr = tr; ev_tu = tu;
    @(negedge clk);
    ev_rr = '0; ev_ro = '0; ev_tr = '0; ev_tu = '0;
  endtask

  task automatic clear_all();
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R1 flags after reset", v, 16'h0000);
    rd(2'd2, v); check("R1 enables after reset", v, 16'h0000);
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_layout();
    logic [15:0] v;
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        logic [1:0] one;
        one = 2'b01 << s;
        pulse(k == 0 ? one : 2'b00, k == 1 ? one : 2'b00,
              k == 2 ? one : 2'b00, k == 3 ? one : 2'b00);
        rd(2'd0, v);
        check("R2 event bit position", v, 16'h0001 << (4*k + s));
        wr(2'd0, 16'hFFFF);
      end
    end
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    pulse(2'b00, 2'b10, 2'b00, 2'b00);
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R4 flag sticky", v, 16'h0020);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    pulse(2'b11, 2'b11, 2'b11, 2'b11);
    rd(2'd0, v); check("R4 all flags set", v, 16'h3333);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R5 write zero no effect", v, 16'h3333);
    wr(2'd0, 16'h0010);
    rd(2'd0, v); check("R5 write one clears bit", v, 16'h3323);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R5 clear all", v, 16'h0000);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); check("R3 enable reserved zero", v, 16'h3333);
    wr(2'd1, 16'hCCCC);
    rd(2'd1, v); check("R3 enable reserved clear ignored", v, 16'h3333);
    wr(2'd1, 16'hFFFF);
    pulse(2'b11, 2'b11, 2'b11, 2'b11);
    wr(2'd0, 16'hCCCC);
    rd(2'd0, v); check("R3 flag reserved write ignored", v, 16'h3333);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_strobe();
    logic [15:0] v;
    pulse(2'b11, 2'b11, 2'b11, 2'b11);
    @(negedge clk); data_wr = 2'b01;
    @(negedge clk); data_wr = 2'b00;
    rd(2'd0, v); check("R6 strobe seq0 only", v, 16'h3233);
    @(negedge clk); data_wr = 2'b10;
    @(negedge clk); data_wr = 2'b00;
    rd(2'd0, v); check("R6 strobe seq1 only", v, 16'h3033);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_setwins();
    logic [15:0] v;
    @(negedge clk);
    ev_rr = 2'b01; bus_addr = 2'd0; bus_wdata = 16'h0001; bus_wr = 1'b1;
    @(negedge clk);
    ev_rr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(2'd0, v); check("R7 event beats write-one", v, 16'h0001);
    @(negedge clk);
    ev_tr = 2'b10; data_wr = 2'b10;
    @(negedge clk);
    ev_tr = '0; data_wr = '0;
    rd(2'd0, v); check("R7 event beats strobe", v, 16'h0201);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    wr(2'd2, 16'h0011);
    rd(2'd2, v); check("R8 enable set", v, 16'h0011);
    wr(2'd2, 16'h0100);
    rd(2'd2, v); check("R8 enable set accumulates", v, 16'h0111);
    wr(2'd1, 16'h0010);
    rd(2'd1, v); check("R8 enable clear via clear addr read", v, 16'h0101);
    rd(2'd2, v); check("R8 enable via set addr read", v, 16'h0101);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(2'd2, 16'h1000);
    pulse(2'b00, 2'b00, 2'b00, 2'b01);
    check("R9 irq one cycle late", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R9 irq raised", {15'd0, irq}, 16'h0001);
    wr(2'd0, 16'h1000);
    check("R9 irq holds one cycle after clear", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R9 irq dropped", {15'd0, irq}, 16'h0000);
    pulse(2'b01, 2'b00, 2'b00, 2'b00);
    repeat (2) @(negedge clk);
    check("R9 masked flag no irq", {15'd0, irq}, 16'h0000);
    wr(2'd2, 16'h0001);
    check("R9 irq waits after enable", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R9 irq after enable", {15'd0, irq}, 16'h0001);
  endtask

  task automatic t_reset_again();
    logic [15:0] v;
    pulse(2'b11, 2'b00, 2'b00, 2'b00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, v); check("R1 reset clears flags", v, 16'h0000);
    rd(2'd2, v); check("R1 reset clears enables", v, 16'h0000);
    check("R1 reset clears irq", {15'd0, irq}, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_sticky();
    t_w1c();
    t_reserved();
    t_strobe();
    t_setwins();
    t_enable();
    t_irq();
    t_reset_again();
    clear_all();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule